// File: doc/BRIEF.md
# Tiny Accumulator CPU with Segmented Paging

This block is a minimal byte-wide accumulator processor. Every address it issues passes through two translation steps. A segment lookup turns a 5-bit logical address into a linear address. A page lookup then turns the linear address into a physical address inside a 32-byte memory made of eight 4-byte frames. Both tables live in the same memory as the program and its data.

The processor holds three byte registers:
- an accumulator;
- a segment-table base;
- a page-table base.

The two base registers take their values from input pins while reset is asserted. The program has no way to change them afterwards.

Instructions are fetched from the code segment (segment 0). Every operand refers to the data segment (segment 1). The block talks to a single synchronous memory port: the read data for an address driven in one cycle appears in the next cycle. The block raises a halted flag once it executes a stop instruction.

Top module: `tcpu_core`

## Requirements
- R1: While rst_ni is low, halted_o is 0 and mem_we_o is 0. mem_addr_o equals stbr_init_i[4:0], which is the first segment-table read for code offset 0.
- R2: A logical address has the segment in bit 4 and the offset in bits 3..0. Translation proceeds as follows, with every sum taken modulo 32:
  - The segment entry's base byte is read at R1 + 2*segment.
  - The linear address is base + offset.
  - The page entry is read at R2 + linear[4:2].
  - The physical address is {frame[2:0], linear[1:0]}.
  - The length byte of the entry and the upper frame bits are ignored.
- R3: The instruction byte carries the opcode in bits 7..5 and the operand offset in bits 3..0. Fetches use segment 0 at the program counter. The program counter is a 4-bit offset that starts at 0 and wraps. Operands always use segment 1.
- R4: Opcode 001 loads the operand into the accumulator. Opcode 010 adds the operand to the accumulator. Opcode 011 subtracts the operand from the accumulator. Results are taken modulo 256.
- R5: Opcode 100 writes the accumulator to the translated data address, with mem_we_o high for exactly one cycle.
- R6: Opcode 111 raises halted_o, which stays high until reset. After that the block makes no memory write.
- R7: Opcodes 000, 101 and 110 change neither the accumulator nor memory. The program counter still advances.
- R8: A load, add, subtract or store takes 8 cycles. A no-op takes 4 cycles. halted_o rises 4 cycles after the fetch of the stop instruction begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stbr_init_i | input | 8 | Segment-table base loaded during reset |
| ptbr_init_i | input | 8 | Page-table base loaded during reset |
| mem_addr_o | output | 5 | Physical memory address |
| mem_we_o | output | 1 | Memory write enable |
| mem_wdata_o | output | 8 | Memory write data (accumulator) |
| mem_rdata_i | input | 8 | Memory read data, one cycle after the address |
| halted_o | output | 1 | High once a stop instruction has executed |

## Verification
The bench runs two hand-built programs and a sweep of pseudo-random memory images with random base registers. For each run, an arithmetic reference interpreter predicts the final memory contents and the cycle count.

The random images make tables overlap with code and data, so stores rewrite page entries, segment entries and instructions. A design that cached a translation, or that ignored the modulo-32 wrap of base plus offset, would leave a different final image. A design that used the length byte, or the upper frame bits, as part of the address would do the same.

The directed programs cover accumulator overflow and underflow, and all three no-op encodings. A design that skipped the program counter increment on a no-op, or that spent memory cycles on it, would miss the predicted cycle count. Writes after halt would show up as a changed image after the extra idle cycles.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;
  localparam int OPC_W = 3;

  localparam logic [OPC_W-1:0] OP_LOAD  = 3'b001;
  localparam logic [OPC_W-1:0] OP_ADD   = 3'b010;
  localparam logic [OPC_W-1:0] OP_SUB   = 3'b011;
  localparam logic [OPC_W-1:0] OP_STORE = 3'b100;
  localparam logic [OPC_W-1:0] OP_HALT  = 3'b111;

  // SEG: segment entry read, PTE: page entry read, ACC: target access,
  // DONE: target data returns
  typedef enum logic [2:0] {
    ST_SEG  = 3'd0,
    ST_PTE  = 3'd1,
    ST_ACC  = 3'd2,
    ST_DONE = 3'd3,
    ST_HALT = 3'd4
  } st_e;

  function automatic logic is_memop(input logic [OPC_W-1:0] op);
    return (op == OP_LOAD) || (op == OP_ADD) || (op == OP_SUB) || (op == OP_STORE);
  endfunction
endpackage

// File: rtl/tcpu_xlate.sv
module tcpu_xlate
  import tcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 2
) (
  input  st_e                 step_i,
  input  logic                seg_i,
  input  logic [ADDR_W-2:0]   off_i,
  input  logic [DATA_W-1:0]   stbr_i,
  input  logic [DATA_W-1:0]   ptbr_i,
  input  logic [DATA_W-1:0]   rdata_i,
  input  logic [PAGE_W-1:0]   lin_lo_i,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [PAGE_W-1:0]   lin_lo_o
);
  localparam int FRAME_W   = ADDR_W - PAGE_W;
  localparam int ENT_SHIFT = 1;  // two bytes per segment entry

  logic [ADDR_W-1:0] lin;

  always_comb begin
    // in ST_PTE, rdata_i carries the segment base
    lin      = rdata_i[ADDR_W-1:0] + ADDR_W'(off_i);
    lin_lo_o = lin[PAGE_W-1:0];
    unique case (step_i)
      ST_SEG:  addr_o = stbr_i[ADDR_W-1:0] + (ADDR_W'(seg_i) << ENT_SHIFT);
      ST_PTE:  addr_o = ptbr_i[ADDR_W-1:0] + ADDR_W'(lin[ADDR_W-1:PAGE_W]);
      ST_ACC:  addr_o = {rdata_i[FRAME_W-1:0], lin_lo_i};
      default: addr_o = '0;
    endcase
  end
endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OPC_W-1:0]  op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0] res_o
);
  always_comb begin
    unique case (op_i)
      OP_LOAD: res_o = opnd_i;
      OP_ADD:  res_o = acc_i + opnd_i;
      OP_SUB:  res_o = acc_i - opnd_i;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int PAGE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] stbr_init_i,
  input  logic [DATA_W-1:0] ptbr_init_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_we_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              halted_o
);
  localparam int OFF_W = ADDR_W - 1;

  st_e               st_q;
  logic              data_ph_q;
  logic [OFF_W-1:0]  pc_q;
  logic [DATA_W-1:0] ir_q;
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] stbr_q;
  logic [DATA_W-1:0] ptbr_q;
  logic [PAGE_W-1:0] lin_lo_q;

  logic [OFF_W-1:0]  cur_off;
  logic [PAGE_W-1:0] lin_lo;
  logic [DATA_W-1:0] alu_res;
  logic [OPC_W-1:0]  ir_op;
  logic [OPC_W-1:0]  fetch_op;

  assign ir_op    = ir_q[DATA_W-1 -: OPC_W];
  assign fetch_op = mem_rdata_i[DATA_W-1 -: OPC_W];
  assign cur_off  = data_ph_q ? ir_q[OFF_W-1:0] : pc_q;

  tcpu_xlate #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PAGE_W (PAGE_W)
  ) u_xlate (
    .step_i   (st_q),
    .seg_i    (data_ph_q),
    .off_i    (cur_off),
    .stbr_i   (stbr_q),
    .ptbr_i   (ptbr_q),
    .rdata_i  (mem_rdata_i),
    .lin_lo_i (lin_lo_q),
    .addr_o   (mem_addr_o),
    .lin_lo_o (lin_lo)
  );

  tcpu_alu #(
    .DATA_W (DATA_W)
  ) u_alu (
    .op_i   (ir_op),
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .res_o  (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_SEG;
      data_ph_q <= 1'b0;
      pc_q      <= '0;
      ir_q      <= '0;
      acc_q     <= '0;
      stbr_q    <= stbr_init_i;
      ptbr_q    <= ptbr_init_i;
      lin_lo_q  <= '0;
    end else begin
      unique case (st_q)
        ST_SEG: st_q <= ST_PTE;
        ST_PTE: begin
          lin_lo_q <= lin_lo;
          st_q     <= ST_ACC;
        end
        ST_ACC: st_q <= ST_DONE;
        ST_DONE: begin
          if (!data_ph_q) begin
            ir_q <= mem_rdata_i;
            if (fetch_op == OP_HALT) begin
              st_q <= ST_HALT;
            end else if (is_memop(fetch_op)) begin
              data_ph_q <= 1'b1;
              st_q      <= ST_SEG;
            end else begin
              pc_q <= pc_q + OFF_W'(1);
              st_q <= ST_SEG;
            end
          end else begin
            if (ir_op != OP_STORE) acc_q <= alu_res;
            pc_q      <= pc_q + OFF_W'(1);
            data_ph_q <= 1'b0;
            st_q      <= ST_SEG;
          end
        end
        ST_HALT: st_q <= ST_HALT;
        default: st_q <= ST_HALT;
      endcase
    end
  end

  assign mem_we_o    = (st_q == ST_ACC) && data_ph_q && (ir_op == OP_STORE);
  assign mem_wdata_o = acc_q;
  assign halted_o    = (st_q == ST_HALT);
endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk
  import tcpu_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic mem_we_o,
  input logic halted_o,
  input st_e  st_i
);
  AST_HALT_STICKY:   assert property (@(posedge clk_i) disable iff (!rst_ni) halted_o |=> halted_o); // R6
  AST_HALT_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni) halted_o |-> !mem_we_o); // R6
  AST_WRITE_SINGLE:  assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o |=> !mem_we_o); // R5
  AST_WRITE_TO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni) mem_we_o |=> (st_i == ST_DONE)); // R5
  AST_SEG_THEN_PTE:  assert property (@(posedge clk_i) disable iff (!rst_ni) (st_i == ST_SEG) |=> (st_i == ST_PTE)); // R8
  AST_PTE_THEN_ACC:  assert property (@(posedge clk_i) disable iff (!rst_ni) (st_i == ST_PTE) |=> (st_i == ST_ACC)); // R8
  AST_DONE_EXIT:     assert property (@(posedge clk_i) disable iff (!rst_ni)
                       (st_i == ST_DONE) |=> (st_i == ST_SEG || st_i == ST_HALT)); // R8
endmodule

bind tcpu_core tcpu_core_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mem_we_o (mem_we_o),
  .halted_o (halted_o),
  .st_i     (st_q)
);

// File: tb/tcpu_core_tb_top.sv
module tcpu_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_RAND     = 40;
  localparam int RUN_LIMIT  = 1000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] stbr = '0, ptbr = '0;
  logic [4:0] addr;
  logic       we;
  logic [7:0] wdata, rdata;
  logic       halted;

  logic [7:0] mem [32];
  logic       ld_en = 1'b0;
  logic [4:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  logic [7:0] img [32];
  logic [7:0] ref_mem [32];
  int n_chk = 0, n_fail = 0;
  logic [31:0] rs = 32'h2545_f491;
  bit done_flag = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcpu_core dut_i (
    .clk_i (clk), .rst_ni (rst_n), .stbr_init_i (stbr), .ptbr_init_i (ptbr),
    .mem_addr_o (addr), .mem_we_o (we), .mem_wdata_o (wdata),
    .mem_rdata_i (rdata), .halted_o (halted)
  );

  always @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    else if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic rnd(output logic [7:0] b);
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    b = rs[15:8];
  endtask

  // R2 reference translation
  function automatic logic [4:0] ref_xl(input logic [4:0] la);
    logic [4:0] sa, lin, pa;
    logic [7:0] base, fr;
    sa   = stbr[4:0] + {3'b0, la[4], 1'b0};
    base = ref_mem[sa];
    lin  = base[4:0] + {1'b0, la[3:0]};
    pa   = ptbr[4:0] + {2'b0, lin[4:2]};
    fr   = ref_mem[pa];
    return {fr[2:0], lin[1:0]};
  endfunction

  task automatic ref_run(output int cyc, output bit hit_halt);
    logic [3:0] pc = '0;
    logic [7:0] acc = '0, ib;
    logic [4:0] pa;
    cyc = 0;
    hit_halt = 0;
    for (int s = 0; s < 64; s++) begin
      ib = ref_mem[ref_xl({1'b0, pc})];
      if (ib[7:5] == 3'b111) begin
        cyc += 4;
        hit_halt = 1;
        break;
      end
      if (ib[7:5] inside {3'b001, 3'b010, 3'b011, 3'b100}) begin
        pa = ref_xl({1'b1, ib[3:0]});
        case (ib[7:5])
          3'b001: acc = ref_mem[pa];
          3'b010: acc = acc + ref_mem[pa];
          3'b011: acc = acc - ref_mem[pa];
          default: ref_mem[pa] = acc;
        endcase
        cyc += 8;
      end else begin
        cyc += 4;  // R7 no-op
      end
      pc = pc + 4'd1;
    end
  endtask

  task automatic run_scn(output int exp_cyc);
    int  cyc;
    bit  hh;
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      ld_en = 1'b1; ld_addr = 5'(i); ld_data = img[i];
    end
    @(negedge clk);
    ld_en = 1'b0;
    @(negedge clk);
    chk(halted == 1'b0, "R1 halted in reset", int'(halted), 0);
    chk(we == 1'b0, "R1 write enable in reset", int'(we), 0);
    chk(addr == stbr[4:0], "R1 first address", int'(addr), int'(stbr[4:0]));
    for (int i = 0; i < 32; i++) ref_mem[i] = img[i];
    ref_run(exp_cyc, hh);
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < RUN_LIMIT) begin
      @(negedge clk);
      cyc++;
    end
    chk(halted == 1'b1, "R6 halted after stop", int'(halted), 1);
    chk(cyc == exp_cyc, "R8 cycle count", cyc, exp_cyc);
    repeat (16) @(negedge clk);
    chk(halted == 1'b1, "R6 halted sticky", int'(halted), 1);
    for (int i = 0; i < 32; i++)
      chk(mem[i] == ref_mem[i], $sformatf("R2 R4 R5 image byte %0d", i), int'(mem[i]), int'(ref_mem[i]));
  endtask

  // shared table layout for the directed programs
  task automatic base_layout();
    for (int i = 0; i < 32; i++) img[i] = 8'h00;
    stbr = 8'd28; ptbr = 8'd20;
    img[28] = 8'd0;  img[29] = 8'd16;   // code segment: base 0
    img[30] = 8'd12; img[31] = 8'd8;    // data segment: base 12
    img[20] = 8'd1; img[21] = 8'd2; img[22] = 8'd3; img[23] = 8'd0; img[24] = 8'd4;
  endtask

  initial begin
    int ec;
    logic [7:0] b;
    int  tmp;
    bit  hh;
    // directed 0: load/add/sub/store through two data pages
    base_layout();
    img[4] = 8'h21; img[5] = 8'h45; img[6] = 8'h62; img[7] = 8'h86; img[8] = 8'hE0;
    img[1] = 8'h30; img[17] = 8'h25; img[2] = 8'h11;
    run_scn(ec);
    chk(mem[18] == 8'h44, "R4 R5 directed result", int'(mem[18]), 'h44);
    chk(ec == 36, "R8 directed cycles", ec, 36);

    // directed 1: wrap-around arithmetic and all no-op encodings (R7)
    base_layout();
    img[4] = 8'h00; img[5] = 8'hA5; img[6] = 8'h20; img[7] = 8'h41; img[8] = 8'h83;
    img[9] = 8'hC0; img[10] = 8'h62; img[11] = 8'h84; img[12] = 8'hE0;
    img[0] = 8'hF0; img[1] = 8'h20; img[2] = 8'h30;
    run_scn(ec);
    chk(mem[3] == 8'h10, "R4 add overflow", int'(mem[3]), 'h10);
    chk(mem[16] == 8'hE0, "R4 sub underflow", int'(mem[16]), 'hE0);
    chk(ec == 56, "R7 R8 no-op cycles", ec, 56);

    // random sweep: overlapping tables, self-modifying code (R2 R3)
    for (int n = 0; n < N_RAND; n++) begin
      for (int i = 0; i < 32; i++) begin rnd(b); img[i] = b; end
      rnd(b); stbr = b;
      rnd(b); ptbr = b;
      for (int i = 0; i < 32; i++) ref_mem[i] = img[i];
      ref_run(tmp, hh);
      if (hh) run_scn(ec);
    end
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule